// File: doc/BRIEF.md
# Four-Channel Interrupt Prioritiser with Acknowledge Response

This block collects the interrupt requests of four motor-control channels and drives one shared bus interrupt line at level 4. A priority encoder reduces the four request lines to a "some request present" flag and a two-bit code naming the highest-numbered requesting channel. The shared line is asserted only while a request is present, a one-shot global enable is armed, and a board-level line-enable input is set.

The global enable is armed by an address-only access, with no data phase, at channel offset 0x1E. Software does not need to clear any individual source to re-arm it. Each answered acknowledge cancels the enable, so software arms it again after every service. When an acknowledge cycle at level 4 arrives while a request is present, the code is latched for the whole cycle, and the 16-bit request word of the selected channel is returned on the read bus. An acknowledge at another level, or one that finds no request, is not answered. It is forwarded instead, and a one-cycle pass-through pulse marks the forwarding.

Top module: `irq_prio_ack`

## Requirements
- R1: After reset, `irq_out`, `rd_valid` and `iack_pass` are 0, and the global enable is disarmed, so `irq_out` stays 0 even while requests are held and `line_en` is 1.
- R2: The selected channel is the highest-numbered channel whose `req` bit is 1. Channel k is `req[k]`, and channel 3 has the highest priority.
- R3: `irq_out` is 1 exactly when at least one `req` bit is 1, the global enable is armed and `line_en` is 1. It follows `req` and `line_en` within the same cycle.
- R4: A rising edge of `addr_stb` while `bus_addr[5:1]` equals 5'b01111 (byte offset 0x1E) arms the global enable from the next clock edge. A strobe at any other offset leaves the enable unchanged.
- R5: A valid acknowledge disarms the global enable at the clock edge that detects it, so `irq_out` is 0 from that edge on. A valid acknowledge is a rising edge of `iack_stb` with `bus_addr[3:1]` equal to 3'b100 and at least one `req` bit set.
- R6: After a valid acknowledge, `rd_valid` is 1 from the detecting edge until the first edge at which `iack_stb` is sampled 0. While `rd_valid` is 1, `rd_data` equals `req_data[16*k+15:16*k]` of the selected channel k. While `rd_valid` is 0, `rd_data` is 0.
- R7: The channel code is latched at the detecting edge. It does not change for the rest of the acknowledge cycle, even when a higher-numbered request arrives during that cycle.
- R8: An acknowledge edge with `bus_addr[3:1]` not equal to 3'b100, or with no request present, is not answered. `rd_valid` stays 0, the global enable is unchanged, and `iack_pass` is 1 for exactly one cycle after the detecting edge.
- R9: The enable can be re-armed after a service while the same requests are still held, and `irq_out` then rises again without any source being cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Bus address bits [5:1] (offset within a channel window) |
| addr_stb | input | 1 | Address-only access strobe |
| iack_stb | input | 1 | Interrupt-acknowledge strobe, high for the whole cycle |
| req | input | 4 | Per-channel interrupt requests, bit k = channel k |
| req_data | input | 64 | Per-channel 16-bit request words, channel k at [16k+15:16k] |
| line_en | input | 1 | Jumper-style enable of the shared interrupt line |
| irq_out | output | 1 | Shared level-4 interrupt request |
| rd_data | output | 16 | Acknowledge response data |
| rd_valid | output | 1 | Response data is being driven |
| iack_pass | output | 1 | One-cycle pulse: the acknowledge was forwarded, not answered |

## Verification
The bench raises a higher-priority request in the middle of an acknowledge cycle. A design that did not latch the code would switch its response to the new channel. Acknowledges at the wrong level, and at level 4 with no request present, must produce only the pass pulse and leave the enable armed. A design that cancelled the enable on any acknowledge would then fail to raise the line again once a request appears. Strobes at a neighbouring offset must not arm the enable. Re-arming with the requests still held must raise the line at once, which catches a design that waits for the sources to be released.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned ACK_LVL_W = 3;
  localparam logic [ACK_LVL_W-1:0] ACK_LEVEL = 3'b100;
  localparam int unsigned ARM_OFS_W = 5;
  localparam logic [ARM_OFS_W-1:0] ARM_OFFSET = 5'b01111; // byte 0x1E

  // Index of the highest set bit among the low n bits of v (0 if none).
  function automatic int unsigned highest_set(input logic [31:0] v,
                                              input int unsigned n);
    int unsigned idx;
    idx = 0;
    for (int unsigned i = 0; i < 32; i++) begin
      if (i < n && v[i]) idx = i;
    end
    return idx;
  endfunction

  function automatic logic any_set(input logic [31:0] v, input int unsigned n);
    logic r;
    r = 1'b0;
    for (int unsigned i = 0; i < 32; i++) begin
      if (i < n && v[i]) r = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_prio_encoder.sv
module irq_prio_encoder
  import irq_prio_pkg::*;
#(
  parameter int unsigned NCH = 4,
  localparam int unsigned CODE_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    req,
  output logic              any_req,
  output logic [CODE_W-1:0] code
);
  logic [31:0] req_ext;

  always_comb begin
    req_ext = '0;
    req_ext[NCH-1:0] = req;
    any_req = any_set(req_ext, NCH);
    code    = CODE_W'(highest_set(req_ext, NCH));
  end

  // the chosen channel really is requesting
  p_code_is_requester_r2: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |-> req[code]);

  // no channel above the chosen one is requesting
  p_none_higher_r2: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |-> ((req >> code) == {{(NCH-1){1'b0}}, 1'b1}));
endmodule

// File: rtl/irq_gie_ctrl.sv
module irq_gie_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ADDR_W:1] bus_addr,
  input  logic            addr_stb,
  input  logic            ack_valid_ev,
  output logic            arm_ev,
  output logic            gie
);
  logic stb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= addr_stb;
  end

  assign arm_ev = addr_stb && !stb_q && (bus_addr[ARM_OFS_W:1] == ARM_OFFSET);

  // an answered acknowledge cancels the enable and wins over a simultaneous arm
  always_ff @(posedge clk) begin
    if (!rst_n)            gie <= 1'b0;
    else if (ack_valid_ev) gie <= 1'b0;
    else if (arm_ev)       gie <= 1'b1;
  end

  p_arm_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_ev && !ack_valid_ev) |=> gie);

  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid_ev |=> !gie);

  p_gie_rises_only_by_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gie) |-> $past(arm_ev));
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned CODE_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W:1]       bus_addr,
  input  logic                  iack_stb,
  input  logic                  any_req,
  input  logic [CODE_W-1:0]     code,
  input  logic [NCH*DATA_W-1:0] req_data,
  output logic                  ack_valid_ev,
  output logic                  rd_valid,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  iack_pass
);
  logic              iack_q;
  logic              ack_edge;
  logic              level_ok;
  logic              ack_pass_ev;
  logic [CODE_W-1:0] code_q;

  assign ack_edge     = iack_stb && !iack_q;
  assign level_ok     = (bus_addr[ACK_LVL_W:1] == ACK_LEVEL);
  assign ack_valid_ev = ack_edge && level_ok && any_req;
  assign ack_pass_ev  = ack_edge && !(level_ok && any_req);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iack_q    <= 1'b0;
      rd_valid  <= 1'b0;
      code_q    <= '0;
      iack_pass <= 1'b0;
    end else begin
      iack_q    <= iack_stb;
      iack_pass <= ack_pass_ev;
      if (ack_valid_ev) begin
        rd_valid <= 1'b1;
        code_q   <= code;
      end else if (!iack_stb) begin
        rd_valid <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_valid) rd_data = req_data[int'(code_q)*DATA_W +: DATA_W];
  end

  p_code_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(rd_valid)) |-> $stable(code_q));

  p_pass_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    iack_pass |=> !iack_pass);

  p_pass_not_answer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    iack_pass |-> !$rose(rd_valid));

  p_answer_needs_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(iack_stb));
endmodule

// File: rtl/irq_prio_ack.sv
module irq_prio_ack
  import irq_prio_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned CODE_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W:1]       bus_addr,
  input  logic                  addr_stb,
  input  logic                  iack_stb,
  input  logic [NCH-1:0]        req,
  input  logic [NCH*DATA_W-1:0] req_data,
  input  logic                  line_en,
  output logic                  irq_out,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  rd_valid,
  output logic                  iack_pass
);
  logic              any_req;
  logic [CODE_W-1:0] code;
  logic              ack_valid_ev;
  logic              arm_ev;
  logic              gie;

  irq_prio_encoder #(.NCH(NCH)) u_enc (
    .clk(clk), .rst_n(rst_n), .req(req), .any_req(any_req), .code(code)
  );

  irq_gie_ctrl #(.ADDR_W(ADDR_W)) u_gie (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .addr_stb(addr_stb),
    .ack_valid_ev(ack_valid_ev), .arm_ev(arm_ev), .gie(gie)
  );

  irq_ack_ctrl #(.NCH(NCH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ack (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .iack_stb(iack_stb),
    .any_req(any_req), .code(code), .req_data(req_data),
    .ack_valid_ev(ack_valid_ev), .rd_valid(rd_valid), .rd_data(rd_data),
    .iack_pass(iack_pass)
  );

  assign irq_out = any_req && gie && line_en;

  p_irq_drops_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid_ev |=> !irq_out);

  p_irq_needs_request_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (req != '0));

  p_answer_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && iack_pass));
endmodule

// File: tb/irq_prio_ack_tb_top.sv
module irq_prio_ack_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:1]  bus_addr = '0;
  logic        addr_stb = 1'b0;
  logic        iack_stb = 1'b0;
  logic [3:0]  req = '0;
  logic [63:0] req_data;
  logic        line_en = 1'b1;
  logic        irq_out;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic        iack_pass;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // scoreboard: 1 = answered with data, 0 = forwarded
  bit          exp_kind[$];
  logic [15:0] exp_data[$];
  logic        prev_valid = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] word_of(input int k);
    return 16'hA000 + 16'(k) * 16'h0111;
  endfunction

  initial begin
    for (int k = 0; k < 4; k++) req_data[k*16 +: 16] = word_of(k);
  end

  irq_prio_ack dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .addr_stb(addr_stb),
    .iack_stb(iack_stb), .req(req), .req_data(req_data), .line_en(line_en),
    .irq_out(irq_out), .rd_data(rd_data), .rd_valid(rd_valid),
    .iack_pass(iack_pass)
  );

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when the design answers or forwards
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid && !prev_valid) begin
        if (exp_kind.size() == 0) check("R6 unexpected answer", 1, 0);
        else begin
          check("R8 answer kind", 32'(exp_kind.pop_front()), 1);
          check("R6 answer data", rd_data, exp_data.pop_front());
        end
      end
      if (iack_pass) begin
        if (exp_kind.size() == 0) check("R8 unexpected pass", 1, 0);
        else begin
          check("R8 pass kind", 32'(exp_kind.pop_front()), 0);
          void'(exp_data.pop_front());
        end
      end
    end
    prev_valid = rd_valid;
  end

  task automatic arm(input logic [5:1] ofs);
    @(negedge clk);
    bus_addr = ofs; addr_stb = 1'b1;
    @(negedge clk);
    addr_stb = 1'b0;
  endtask

  // answered: expect data of channel ch; raise_hi sets req[3] mid-cycle
  task automatic ack(input logic [3:1] lvl, input bit answered, input int ch,
                     input bit raise_hi);
    @(negedge clk);
    exp_kind.push_back(answered);
    exp_data.push_back(answered ? word_of(ch) : 16'h0);
    bus_addr = {2'b00, lvl}; iack_stb = 1'b1;
    @(negedge clk);
    if (!answered) begin
      check("R8 no answer", rd_valid, 0);
      @(negedge clk);
      check("R8 pass width", iack_pass, 0);
    end else begin
      if (raise_hi) req[3] = 1'b1;
      @(negedge clk);
      check("R7 held data", rd_data, word_of(ch));
      check("R6 valid held", rd_valid, 1);
    end
    iack_stb = 1'b0;
    @(negedge clk);
    check("R6 valid ends", rd_valid, 0);
    check("R6 data zero", rd_data, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq reset", irq_out, 0);
    check("R1 valid reset", rd_valid, 0);
    check("R1 pass reset", iack_pass, 0);
    rst_n = 1'b1;
    req = 4'b0011;
    @(negedge clk);
    check("R1 disarmed", irq_out, 0);

    arm(5'b01111);
    check("R4 armed", irq_out, 1);
    line_en = 1'b0; #1;
    check("R3 line_en off", irq_out, 0);
    line_en = 1'b1; req = 4'b0000; #1;
    check("R3 no request", irq_out, 0);
    req = 4'b0011; #1;
    check("R3 request", irq_out, 1);

    // R2 R7: channel 1 chosen, higher request mid-cycle ignored
    ack(3'b100, 1'b1, 1, 1'b1);
    check("R5 disarmed after ack", irq_out, 0);

    // R9 re-arm with sources still held
    arm(5'b01111);
    check("R9 rearm", irq_out, 1);

    // R8 wrong level: forwarded, enable kept
    ack(3'b011, 1'b0, 0, 1'b0);
    check("R8 enable kept", irq_out, 1);

    // R2 patterns
    ack(3'b100, 1'b1, 3, 1'b0);
    req = 4'b0101;
    arm(5'b01111);
    ack(3'b100, 1'b1, 2, 1'b0);
    req = 4'b0001;
    arm(5'b01111);
    ack(3'b100, 1'b1, 0, 1'b0);

    // R4 other offset leaves enable disarmed
    arm(5'b01110);
    check("R4 other offset", irq_out, 0);

    // R8 no request at level 4: forwarded, enable survives
    arm(5'b01111);
    req = 4'b0000;
    ack(3'b100, 1'b0, 0, 1'b0);
    req = 4'b1000; #1;
    check("R8 enable survives", irq_out, 1);
    req = 4'b1111;
    ack(3'b100, 1'b1, 3, 1'b0);
    check("R5 cleared again", irq_out, 0);

    repeat (2) @(negedge clk);
    check("R6 scoreboard empty", exp_kind.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule